// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a segment:offset logical address into a linear address. Each request names a segment slot, a 16-bit segment value or selector, a 32-bit offset and whether the access is a write. A mode input, sampled with every request, picks one of two computations.

In real mode the segment value is scaled by sixteen and added to the low half of the offset, giving a 20-bit address. In protected mode the selector must match the descriptor held in the chosen slot. That descriptor supplies a 32-bit base, a 20-bit limit with byte or 4 KB granularity, and access rights. The offset is checked against the limit and against the access rights, and then added to the base. Descriptors are written into the per-slot cache through a load port. The result, or a fault code with a zeroed address, appears one clock after the request strobe.

Top module: `seg_xlate_top`

## Requirements
- R1: In real mode (prot_mode_i=0) the result is ({sel_i,4'h0} + offset_i[15:0]) truncated to 20 bits and zero-extended to 32 bits. offset_i[31:16] is ignored, the slot contents are ignored, and no fault is raised.
- R2: In protected mode, a request that passes all checks returns the descriptor base plus offset_i, modulo 2^32.
- R3: A protected-mode request hits only if its slot has been loaded and the loaded selector bits [15:3] (table index) and bit [2] (table indicator, 0 global, 1 local) equal those of sel_i. Selector bits [1:0] take no part in the match. A slot number of NUM_SLOTS or above never hits. A miss gives fault code 1.
- R4: With granularity 0 the limit counts bytes. An offset greater than the limit gives fault code 2, and an offset equal to the limit passes.
- R5: With granularity 1 the effective limit is {limit, 12'hFFF}, and the same comparison as R4 applies.
- R6: A write (wr_i=1) to a code segment, or to a data segment loaded as not writable, gives fault code 3. Reads of either kind of segment, and writes to writable data, pass.
- R7: Fault priority is miss (1) over limit (2) over protection (3).
- R8: When a fault is reported, fault_o=1 and lin_addr_o=0. Without a fault, fault_o=0 and fault_code_o=0.
- R9: vld_o is high in exactly the cycle after each cycle with req_i high. Back-to-back requests each give one result, in order.
- R10: After reset vld_o, fault_o, fault_code_o and lin_addr_o are 0, and every slot is empty.
- R11: A load replaces only its own slot. A request in the same cycle as a load to its slot sees the previous contents, and later requests see the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Load strobe for the descriptor cache |
| ld_slot_i | input | SlotW | Slot to load |
| ld_sel_i | input | 16 | Selector tagged to the loaded descriptor |
| ld_base_i | input | 32 | Descriptor base |
| ld_limit_i | input | 20 | Descriptor limit |
| ld_gran_i | input | 1 | 1: limit in 4 KB units, 0: bytes |
| ld_code_i | input | 1 | 1: code segment, 0: data segment |
| ld_wr_ok_i | input | 1 | 1: data segment writable |
| req_i | input | 1 | Translation request strobe |
| prot_mode_i | input | 1 | 1: protected mode, 0: real mode |
| slot_i | input | SlotW | Segment slot used by the request |
| sel_i | input | 16 | Segment value (real) or selector (protected) |
| offset_i | input | 32 | Offset |
| wr_i | input | 1 | 1: write access |
| vld_o | output | 1 | Result valid |
| lin_addr_o | output | 32 | Linear address, 0 on fault |
| fault_o | output | 1 | Fault flag |
| fault_code_o | output | 2 | 0 none, 1 miss, 2 limit, 3 protection |

## Verification
The bench targets the limit boundary in both granularities. Offsets exactly at the effective limit must pass and one above must fault, so a design that used >= or forgot the 12 filled low bits would either reject legal edge accesses or admit one extra page. Base-plus-offset wraparound and the 20-bit real-mode carry are exercised, which exposes a sum of the wrong width. Selectors that differ only in the table bit, or only in the request-privilege bits, check that the tag compare covers exactly bits [15:2]. A write that is both over the limit and to a code segment, together with a request issued in the same cycle as a reload of its slot, checks fault priority and the ordering of loads against lookups.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W  = 16;
  localparam int TAG_W  = 14;  // selector bits [15:2]: index and table bit
  localparam int BASE_W = 32;
  localparam int LIM_W  = 20;
  localparam int PAGE_SH = 12;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              code;
    logic              wr_ok;
  } seg_desc_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_MISS  = 2'd1,
    FLT_LIMIT = 2'd2,
    FLT_PROT  = 2'd3
  } flt_e;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [SLOT_W-1:0] ld_slot_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  seg_desc_t         ld_desc_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              hit_o,
  output seg_desc_t         desc_o
);
  logic [NUM_SLOTS-1:0] slot_vld;
  logic [TAG_W-1:0]     slot_tag  [NUM_SLOTS];
  seg_desc_t            slot_desc [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    seg_desc_t        d_q;
    logic             we;

    assign we = ld_en_i && (ld_slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else if (we) begin
        v_q <= 1'b1;
        t_q <= ld_tag_i;
        d_q <= ld_desc_i;
      end
    end

    assign slot_vld[g]  = v_q;
    assign slot_tag[g]  = t_q;
    assign slot_desc[g] = d_q;
  end

  // out-of-range slot numbers fall through as a miss
  always_comb begin
    hit_o  = 1'b0;
    desc_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_slot_i == SLOT_W'(i)) begin
        hit_o  = slot_vld[i] && (slot_tag[i] == rd_tag_i);
        desc_o = slot_desc[i];
      end
    end
  end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
  import seg_xlate_pkg::*;
(
  input  logic [BASE_W-1:0] offset_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              gran_i,
  output logic              over_o
);
  logic [BASE_W-1:0] eff_lim;

  always_comb begin
    if (gran_i) eff_lim = {limit_i, {PAGE_SH{1'b1}}};
    else        eff_lim = {{(BASE_W-LIM_W){1'b0}}, limit_i};
    over_o = offset_i > eff_lim;
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk (
  input  logic code_i,
  input  logic wr_ok_i,
  input  logic wr_i,
  output logic viol_o
);
  assign viol_o = wr_i && (code_i || !wr_ok_i);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  localparam int SlotW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [SlotW-1:0] ld_slot_i,
  input  logic [15:0]      ld_sel_i,
  input  logic [31:0]      ld_base_i,
  input  logic [19:0]      ld_limit_i,
  input  logic             ld_gran_i,
  input  logic             ld_code_i,
  input  logic             ld_wr_ok_i,
  input  logic             req_i,
  input  logic             prot_mode_i,
  input  logic [SlotW-1:0] slot_i,
  input  logic [15:0]      sel_i,
  input  logic [31:0]      offset_i,
  input  logic             wr_i,
  output logic             vld_o,
  output logic [31:0]      lin_addr_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o
);
  localparam int RealW = SEL_W + 4;

  seg_desc_t ld_desc, hit_desc;
  logic      hit, over, viol;

  assign ld_desc = '{base: ld_base_i, limit: ld_limit_i, gran: ld_gran_i,
                     code: ld_code_i, wr_ok: ld_wr_ok_i};

  seg_desc_cache #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SlotW)) u_cache (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (ld_en_i),
    .ld_slot_i (ld_slot_i),
    .ld_tag_i  (ld_sel_i[SEL_W-1:2]),
    .ld_desc_i (ld_desc),
    .rd_slot_i (slot_i),
    .rd_tag_i  (sel_i[SEL_W-1:2]),
    .hit_o     (hit),
    .desc_o    (hit_desc)
  );

  seg_limit_chk u_lim (
    .offset_i (offset_i),
    .limit_i  (hit_desc.limit),
    .gran_i   (hit_desc.gran),
    .over_o   (over)
  );

  seg_access_chk u_acc (
    .code_i  (hit_desc.code),
    .wr_ok_i (hit_desc.wr_ok),
    .wr_i    (wr_i),
    .viol_o  (viol)
  );

  logic [RealW-1:0]  real_sum;
  logic [BASE_W-1:0] prot_sum, nxt_addr;
  flt_e              nxt_flt;

  always_comb begin
    real_sum = {sel_i, 4'h0} + {4'h0, offset_i[SEL_W-1:0]};
    prot_sum = hit_desc.base + offset_i;
    if (!prot_mode_i) nxt_flt = FLT_NONE;
    else if (!hit)    nxt_flt = FLT_MISS;
    else if (over)    nxt_flt = FLT_LIMIT;
    else if (viol)    nxt_flt = FLT_PROT;
    else              nxt_flt = FLT_NONE;
    if (nxt_flt != FLT_NONE) nxt_addr = '0;
    else if (prot_mode_i)    nxt_addr = prot_sum;
    else                     nxt_addr = {{(BASE_W-RealW){1'b0}}, real_sum};
  end

  logic              vld_q;
  logic [BASE_W-1:0] addr_q;
  flt_e              flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      flt_q  <= FLT_NONE;
    end else begin
      vld_q <= req_i;
      if (req_i) begin
        addr_q <= nxt_addr;
        flt_q  <= nxt_flt;
      end
    end
  end

  assign vld_o        = vld_q;
  assign lin_addr_o   = addr_q;
  assign fault_code_o = flt_q;
  assign fault_o      = (flt_q != FLT_NONE);
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        prot_mode_i,
  input logic        vld_o,
  input logic [31:0] lin_addr_o,
  input logic        fault_o,
  input logic [1:0]  fault_code_o
);
  logic req_seen, real_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen  <= 1'b0;
      real_seen <= 1'b0;
    end else begin
      req_seen  <= req_i;
      real_seen <= req_i && !prot_mode_i;
    end
  end

  assert_vld_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == req_seen);

  assert_fault_zero_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && fault_o) |-> (lin_addr_o == 32'h0 && fault_code_o != 2'd0));

  assert_real_no_fault_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && real_seen) |-> !fault_o);

  assert_real_width_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && real_seen) |-> (lin_addr_o[31:20] == 12'h0));
endmodule

bind seg_xlate_top seg_xlate_chk u_chk (.*);

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_slot_i = '0;
  logic [15:0] ld_sel_i = '0;
  logic [31:0] ld_base_i = '0;
  logic [19:0] ld_limit_i = '0;
  logic        ld_gran_i = 1'b0, ld_code_i = 1'b0, ld_wr_ok_i = 1'b0;
  logic        req_i = 1'b0, prot_mode_i = 1'b0, wr_i = 1'b0;
  logic [2:0]  slot_i = '0;
  logic [15:0] sel_i = '0;
  logic [31:0] offset_i = '0;
  logic        vld_o, fault_o;
  logic [31:0] lin_addr_o;
  logic [1:0]  fault_code_o;

  always #10 clk = ~clk;

  seg_xlate_top dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ld_en_i(ld_en_i), .ld_slot_i(ld_slot_i), .ld_sel_i(ld_sel_i),
    .ld_base_i(ld_base_i), .ld_limit_i(ld_limit_i), .ld_gran_i(ld_gran_i),
    .ld_code_i(ld_code_i), .ld_wr_ok_i(ld_wr_ok_i),
    .req_i(req_i), .prot_mode_i(prot_mode_i), .slot_i(slot_i), .sel_i(sel_i),
    .offset_i(offset_i), .wr_i(wr_i),
    .vld_o(vld_o), .lin_addr_o(lin_addr_o), .fault_o(fault_o),
    .fault_code_o(fault_code_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual code=%0d addr=%h expected code=%0d addr=%h",
               tag, act[33:32], act[31:0], exp[33:32], exp[31:0]);
    end
  endtask

  // monitor: pop and compare every result
  always @(negedge clk) begin
    if (rst_ni && vld_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: actual unexpected vld_o=1 expected 0");
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {fault_code_o, lin_addr_o}, e);
        check({t, "/R8 fault_o"}, {33'h0, fault_o}, {33'h0, (e[33:32] != 2'd0)});
      end
    end
  end

  task automatic do_req(input logic pm, input logic [2:0] slot, input logic [15:0] sel,
                        input logic [31:0] off, input logic wr,
                        input logic [1:0] ec, input logic [31:0] ea, input string tag);
    prot_mode_i = pm; slot_i = slot; sel_i = sel; offset_i = off; wr_i = wr;
    req_i = 1'b1;
    exp_q.push_back({ec, ea});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [2:0] slot, input logic [15:0] sel, input logic [31:0] base,
                      input logic [19:0] lim, input logic gran, input logic code, input logic wok);
    ld_slot_i = slot; ld_sel_i = sel; ld_base_i = base; ld_limit_i = lim;
    ld_gran_i = gran; ld_code_i = code; ld_wr_ok_i = wok; ld_en_i = 1'b1;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset", {fault_code_o, lin_addr_o}, 34'h0);
    check("R10 reset flags", {32'h0, vld_o, fault_o}, 34'h0);

    // R1 real mode
    do_req(0, 0, 16'hA1F0, 32'h0000_04C0, 0, 0, 32'h000A_23C0, "R1 real A1F0");
    do_req(0, 0, 16'h028F, 32'h0000_0030, 0, 0, 32'h0000_2920, "R1 real 028F");
    do_req(0, 0, 16'hFFFF, 32'h0000_FFFF, 1, 0, 32'h0000_FFEF, "R1 real carry drop");
    do_req(0, 5, 16'h1000, 32'hABCD_0010, 1, 0, 32'h0001_0010, "R1 real upper offset ignored");
    idle(2);

    // slot 1: index 3 global, byte limit 0xFFF, writable data
    load(1, 16'h0018, 32'h1000_0000, 20'h00FFF, 0, 0, 1);
    // slot 2: index 4 local, 4 KB limit 1, code
    load(2, 16'h0024, 32'hFFFF_F000, 20'h00001, 1, 1, 0);
    // slot 3: index 6 global, full 4 KB limit, read-only data
    load(3, 16'h0030, 32'h0040_0000, 20'hFFFFF, 1, 0, 0);

    do_req(1, 1, 16'h0018, 32'h0000_0123, 0, 0, 32'h1000_0123, "R2 base plus offset");
    do_req(1, 1, 16'h001B, 32'h0000_0123, 0, 0, 32'h1000_0123, "R3 low bits ignored");
    do_req(1, 1, 16'h001C, 32'h0000_0123, 0, 1, 32'h0, "R3 table bit mismatch");
    do_req(1, 1, 16'h0010, 32'h0000_0123, 0, 1, 32'h0, "R3 index mismatch");
    do_req(1, 1, 16'h0018, 32'h0000_0FFF, 0, 0, 32'h1000_0FFF, "R4 at limit");
    do_req(1, 1, 16'h0018, 32'h0000_1000, 0, 2, 32'h0, "R4 over limit");
    do_req(1, 1, 16'h0018, 32'h0000_0040, 1, 0, 32'h1000_0040, "R6 write writable data");
    idle(1);
    do_req(1, 2, 16'h0024, 32'h0000_1FFF, 0, 0, 32'h0000_0FFF, "R5 page limit edge R2 wrap");
    do_req(1, 2, 16'h0024, 32'h0000_2000, 0, 2, 32'h0, "R5 page over limit");
    do_req(1, 2, 16'h0024, 32'h0000_0010, 1, 3, 32'h0, "R6 write code");
    do_req(1, 2, 16'h0024, 32'h0000_2000, 1, 2, 32'h0, "R7 limit over prot");
    do_req(1, 2, 16'h0020, 32'h0000_0010, 0, 1, 32'h0, "R3 global vs local");
    do_req(1, 3, 16'h0030, 32'h0000_0005, 1, 3, 32'h0, "R6 write read-only");
    do_req(1, 3, 16'h0030, 32'hFFFF_FFFF, 0, 0, 32'h003F_FFFF, "R5 full limit read");
    do_req(1, 0, 16'h0000, 32'h0000_0000, 0, 1, 32'h0, "R3 empty slot");
    do_req(1, 0, 16'h0000, 32'h0000_9000, 1, 1, 32'h0, "R7 miss over all");
    do_req(1, 7, 16'h0018, 32'h0000_0000, 0, 1, 32'h0, "R3 slot out of range");
    do_req(0, 3, 16'h0030, 32'h0000_0005, 1, 0, 32'h0000_0305, "R1 real ignores slot");
    idle(2);

    // R11 reload
    load(1, 16'h0018, 32'h2000_0000, 20'h00FFF, 0, 0, 1);
    do_req(1, 1, 16'h0018, 32'h0000_0123, 0, 0, 32'h2000_0123, "R11 reload");
    do_req(1, 3, 16'h0030, 32'h0000_0010, 0, 0, 32'h0040_0010, "R11 other slot kept");
    // same-cycle load and request
    ld_slot_i = 1; ld_sel_i = 16'h0018; ld_base_i = 32'h3000_0000; ld_limit_i = 20'h00FFF;
    ld_gran_i = 0; ld_code_i = 0; ld_wr_ok_i = 1; ld_en_i = 1'b1;
    do_req(1, 1, 16'h0018, 32'h0000_0123, 0, 0, 32'h2000_0123, "R11 same cycle old");
    ld_en_i = 1'b0;
    do_req(1, 1, 16'h0018, 32'h0000_0123, 0, 0, 32'h3000_0123, "R11 next cycle new");
    idle(3);

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9: actual %0d results missing expected 0", exp_q.size());
    end
    finish_up();
  end
endmodule